// File: doc/BRIEF.md
# Programmable Decimating Tap Delay Line

This block holds the sample history for two folded FIR cells, called A and B. Each cell has a forward shift path and a reverse shift path. Each path has four tap positions, one for each multiplier of the cell. Between adjacent taps a sample waits a programmable number of clock-enabled cycles, from 1 to 16. The forward and reverse paths of both cells use that same spacing. The taps of every path come out in parallel to the pre-adders. The last forward tap of each cell also goes out to an external feedback unit, which later returns samples into the reverse paths.

In dual mode the two cells are independent filters. Cell A always takes the A input bus. Cell B takes either the A bus or the B bus, according to a select input. In single mode the cells join into one filter of twice the length:

- Samples run through the forward path of A and then through the forward path of B.
- Feedback samples enter the reverse path of A, then continue through the reverse path of B.

The spacing code is captured only while reset is high, and reset clears every stored sample.

Top module: `tapline_pair`

## Requirements
- R1: With a captured spacing code N and D = N+1, forward tap k (k = 0..3) of a path shows the path input value that was applied (k+1)*D clock-enabled cycles earlier, or zero if fewer such cycles have passed since reset.
- R2: Code 4'b0000 gives a spacing of one clock-enabled cycle, and code 4'b1111 gives a spacing of sixteen.
- R3: Reverse tap k of a path shows the reverse input delayed by (k+1)*D clock-enabled cycles, the same spacing as the forward path.
- R4: With dual_mode = 0 (single mode), cell B forward tap k equals din_a delayed by (k+5)*D cycles. Cell A reverse is fed by fb_a_in, and cell B reverse tap k equals fb_a_in delayed by (k+5)*D cycles. din_b and fb_b_in have no effect.
- R5: With dual_mode = 1, cell B forward input is din_a when b_src_sel = 0 and din_b when b_src_sel = 1, and cell B reverse input is fb_b_in.
- R6: dec_code is captured only on clock edges where rst is high. A change on it while rst is low has no effect on the spacing.
- R7: A clock edge with rst high clears every tap of every path to zero.
- R8: While ce is low, every tap output holds its value, whatever the inputs do.
- R9: fwd_tail_a and fwd_tail_b equal forward tap 3 of cell A and of cell B respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also the spacing-code capture window |
| ce | input | 1 | Advances all delay registers when high |
| dual_mode | input | 1 | 0 = single cascaded filter, 1 = two independent filters |
| b_src_sel | input | 1 | In dual mode, cell B forward source: 0 = din_a, 1 = din_b |
| dec_code | input | 4 | Spacing code N, spacing = N+1 cycles |
| din_a | input | 10 | A sample input bus |
| din_b | input | 10 | B sample input bus |
| fb_a_in | input | 10 | Feedback unit output into cell A reverse path |
| fb_b_in | input | 10 | Feedback unit output into cell B reverse path (dual mode) |
| fwd_taps_a | output | 40 | Cell A forward taps, tap k at bits [10k+9:10k] |
| rev_taps_a | output | 40 | Cell A reverse taps, same packing |
| fwd_taps_b | output | 40 | Cell B forward taps, same packing |
| rev_taps_b | output | 40 | Cell B reverse taps, same packing |
| fwd_tail_a | output | 10 | Cell A last forward tap, to the feedback unit |
| fwd_tail_b | output | 10 | Cell B last forward tap, to the feedback unit |

## Verification
The assertions check four rules on every cycle:

- Each delay stage holds while ce is low and is zero after a reset edge.
- At unit spacing, a stage follows its input by one cycle.
- The captured code never moves outside reset.
- At unit spacing, the routing into cell B matches the mode.

Longer spacings, the full (k+1)*D and (k+5)*D lags across cascaded cells, the B source select under wide spacing, and the fact that din_b and the ignored feedback input have no effect can be shown only by the bench's scenarios. These compare every tap against a history of the applied inputs.

// File: rtl/tapline_pkg.sv
package tapline_pkg;

    localparam int SAMPLE_W  = 10;
    localparam int TAP_COUNT = 4;
    localparam int MAX_SPACE = 16;

    typedef logic [SAMPLE_W-1:0] sample_t;

    typedef enum logic {
        MODE_CASCADE = 1'b0,
        MODE_SPLIT   = 1'b1
    } pair_mode_e;

    typedef struct packed {
        sample_t fwd_in;
        sample_t rev_in;
    } cell_feed_t;

    function automatic pair_mode_e decode_mode(input logic bit_in);
        return bit_in ? MODE_SPLIT : MODE_CASCADE;
    endfunction

endpackage

// File: rtl/tapline_stage.sv
module tapline_stage #(
    parameter int W     = 10,
    parameter int DEPTH = 16,
    parameter int SEL_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ce,
    input  logic [SEL_W-1:0] rd_sel,
    input  logic [W-1:0]     din,
    output logic [W-1:0]     dout
);

    logic [W-1:0] chain [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) chain[i] <= '0;
        end else if (ce) begin
            chain[0] <= din;
            for (int i = 1; i < DEPTH; i++) chain[i] <= chain[i-1];
        end
    end

    assign dout = chain[rd_sel];

    assert_hold_when_idle_R8: assert property (@(posedge clk) disable iff (rst)
        !ce |=> $stable(dout));

    assert_clear_on_reset_R7: assert property (@(posedge clk)
        rst |=> dout == '0);

    assert_unit_spacing_R1: assert property (@(posedge clk) disable iff (rst)
        (ce && rd_sel == '0 && $stable(rd_sel)) |=> dout == $past(din));

endmodule

// File: rtl/tapline_path.sv
module tapline_path #(
    parameter int W     = 10,
    parameter int TAPS  = 4,
    parameter int DEPTH = 16,
    parameter int SEL_W = $clog2(DEPTH)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     ce,
    input  logic [SEL_W-1:0]         rd_sel,
    input  logic [W-1:0]             din,
    output logic [TAPS-1:0][W-1:0]   taps,
    output logic [W-1:0]             tail
);

    logic [W-1:0] link [TAPS+1];

    assign link[0] = din;

    for (genvar k = 0; k < TAPS; k++) begin : g_stage
        tapline_stage #(.W(W), .DEPTH(DEPTH), .SEL_W(SEL_W)) u_stage (
            .clk    (clk),
            .rst    (rst),
            .ce     (ce),
            .rd_sel (rd_sel),
            .din    (link[k]),
            .dout   (link[k+1])
        );
        assign taps[k] = link[k+1];
    end

    assign tail = link[TAPS];

endmodule

// File: rtl/tapline_cell.sv
module tapline_cell
    import tapline_pkg::*;
#(
    parameter int W     = SAMPLE_W,
    parameter int TAPS  = TAP_COUNT,
    parameter int DEPTH = MAX_SPACE,
    parameter int SEL_W = $clog2(DEPTH)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   ce,
    input  logic [SEL_W-1:0]       rd_sel,
    input  logic [W-1:0]           fwd_in,
    input  logic [W-1:0]           rev_in,
    output logic [TAPS-1:0][W-1:0] fwd_taps,
    output logic [TAPS-1:0][W-1:0] rev_taps,
    output logic [W-1:0]           fwd_tail,
    output logic [W-1:0]           rev_tail
);

    tapline_path #(.W(W), .TAPS(TAPS), .DEPTH(DEPTH), .SEL_W(SEL_W)) u_fwd (
        .clk    (clk),
        .rst    (rst),
        .ce     (ce),
        .rd_sel (rd_sel),
        .din    (fwd_in),
        .taps   (fwd_taps),
        .tail   (fwd_tail)
    );

    tapline_path #(.W(W), .TAPS(TAPS), .DEPTH(DEPTH), .SEL_W(SEL_W)) u_rev (
        .clk    (clk),
        .rst    (rst),
        .ce     (ce),
        .rd_sel (rd_sel),
        .din    (rev_in),
        .taps   (rev_taps),
        .tail   (rev_tail)
    );

endmodule

// File: rtl/tapline_pair.sv
module tapline_pair
    import tapline_pkg::*;
#(
    parameter int W      = SAMPLE_W,
    parameter int TAPS   = TAP_COUNT,
    parameter int DEPTH  = MAX_SPACE,
    parameter int CODE_W = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ce,
    input  logic                dual_mode,
    input  logic                b_src_sel,
    input  logic [CODE_W-1:0]   dec_code,
    input  logic [W-1:0]        din_a,
    input  logic [W-1:0]        din_b,
    input  logic [W-1:0]        fb_a_in,
    input  logic [W-1:0]        fb_b_in,
    output logic [TAPS*W-1:0]   fwd_taps_a,
    output logic [TAPS*W-1:0]   rev_taps_a,
    output logic [TAPS*W-1:0]   fwd_taps_b,
    output logic [TAPS*W-1:0]   rev_taps_b,
    output logic [W-1:0]        fwd_tail_a,
    output logic [W-1:0]        fwd_tail_b
);

    logic [CODE_W-1:0] code_q;
    pair_mode_e        mode;
    cell_feed_t        feed_a, feed_b;

    logic [TAPS-1:0][W-1:0] a_fwd, a_rev, b_fwd, b_rev;
    logic [W-1:0]           a_ftail, a_rtail, b_ftail, b_rtail;

    // Spacing code is captured only inside the reset window.
    always_ff @(posedge clk) begin
        if (rst) code_q <= dec_code;
    end

    assign mode = decode_mode(dual_mode);

    always_comb begin
        feed_a.fwd_in = din_a;
        feed_a.rev_in = fb_a_in;
        if (mode == MODE_CASCADE) begin
            feed_b.fwd_in = a_ftail;
            feed_b.rev_in = a_rtail;
        end else begin
            feed_b.fwd_in = b_src_sel ? din_b : din_a;
            feed_b.rev_in = fb_b_in;
        end
    end

    tapline_cell #(.W(W), .TAPS(TAPS), .DEPTH(DEPTH), .SEL_W(CODE_W)) u_cell_a (
        .clk      (clk),
        .rst      (rst),
        .ce       (ce),
        .rd_sel   (code_q),
        .fwd_in   (feed_a.fwd_in),
        .rev_in   (feed_a.rev_in),
        .fwd_taps (a_fwd),
        .rev_taps (a_rev),
        .fwd_tail (a_ftail),
        .rev_tail (a_rtail)
    );

    tapline_cell #(.W(W), .TAPS(TAPS), .DEPTH(DEPTH), .SEL_W(CODE_W)) u_cell_b (
        .clk      (clk),
        .rst      (rst),
        .ce       (ce),
        .rd_sel   (code_q),
        .fwd_in   (feed_b.fwd_in),
        .rev_in   (feed_b.rev_in),
        .fwd_taps (b_fwd),
        .rev_taps (b_rev),
        .fwd_tail (b_ftail),
        .rev_tail (b_rtail)
    );

    assign fwd_taps_a = a_fwd;
    assign rev_taps_a = a_rev;
    assign fwd_taps_b = b_fwd;
    assign rev_taps_b = b_rev;
    assign fwd_tail_a = a_ftail;
    assign fwd_tail_b = b_ftail;

    assert_code_frozen_R6: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $stable(code_q));

    assert_cascade_fwd_R4: assert property (@(posedge clk) disable iff (rst)
        (ce && !dual_mode && code_q == '0) |=> b_fwd[0] == $past(fwd_tail_a));

    assert_split_src_a_R5: assert property (@(posedge clk) disable iff (rst)
        (ce && dual_mode && !b_src_sel && code_q == '0) |=> b_fwd[0] == $past(din_a));

    assert_split_src_b_R5: assert property (@(posedge clk) disable iff (rst)
        (ce && dual_mode && b_src_sel && code_q == '0) |=> b_fwd[0] == $past(din_b));

endmodule

// File: tb/tapline_pair_bench.sv
module tapline_pair_bench;

    localparam int W     = 10;
    localparam int TAPS  = 4;
    localparam int HLEN  = 160;
    localparam time TCLK = 5ns;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ce = 1'b0;
    logic dual_mode = 1'b1;
    logic b_src_sel = 1'b0;
    logic [3:0] dec_code = 4'd0;
    logic [W-1:0] din_a = '0, din_b = '0, fb_a_in = '0, fb_b_in = '0;
    logic [TAPS*W-1:0] fwd_taps_a, rev_taps_a, fwd_taps_b, rev_taps_b;
    logic [W-1:0] fwd_tail_a, fwd_tail_b;

    int ntests = 0;
    int nfail = 0;
    int spacing = 1;
    bit done = 1'b0;

    logic [W-1:0] ha [HLEN];
    logic [W-1:0] hb [HLEN];
    logic [W-1:0] hfa [HLEN];
    logic [W-1:0] hfb [HLEN];

    always #(TCLK/2) clk = ~clk;

    tapline_pair u_tapline_pair (
        .clk(clk), .rst(rst), .ce(ce), .dual_mode(dual_mode), .b_src_sel(b_src_sel),
        .dec_code(dec_code), .din_a(din_a), .din_b(din_b), .fb_a_in(fb_a_in), .fb_b_in(fb_b_in),
        .fwd_taps_a(fwd_taps_a), .rev_taps_a(rev_taps_a),
        .fwd_taps_b(fwd_taps_b), .rev_taps_b(rev_taps_b),
        .fwd_tail_a(fwd_tail_a), .fwd_tail_b(fwd_tail_b)
    );

    // Input history: index 0 holds the value captured at the latest enabled edge.
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < HLEN; i++) begin
                ha[i] = '0; hb[i] = '0; hfa[i] = '0; hfb[i] = '0;
            end
        end else if (ce) begin
            for (int i = HLEN-1; i > 0; i--) begin
                ha[i] = ha[i-1]; hb[i] = hb[i-1]; hfa[i] = hfa[i-1]; hfb[i] = hfb[i-1];
            end
            ha[0] = din_a; hb[0] = din_b; hfa[0] = fb_a_in; hfb[0] = fb_b_in;
        end
    end

    task automatic check_all(input string tag);
        int bad = 0;
        string what = "";
        logic [W-1:0] act = '0, exp = '0;
        for (int k = 0; k < TAPS; k++) begin
            int lag1 = (k+1)*spacing - 1;
            int lag5 = (k+5)*spacing - 1;
            logic [W-1:0] e_af = ha[lag1];
            logic [W-1:0] e_ar = hfa[lag1];
            logic [W-1:0] e_bf = !dual_mode ? ha[lag5] : (b_src_sel ? hb[lag1] : ha[lag1]);
            logic [W-1:0] e_br = !dual_mode ? hfa[lag5] : hfb[lag1];
            if (fwd_taps_a[k*W +: W] !== e_af && bad == 0) begin
                what = $sformatf("fwd A tap%0d", k); act = fwd_taps_a[k*W +: W]; exp = e_af;
            end
            if (fwd_taps_a[k*W +: W] !== e_af) bad++;
            if (rev_taps_a[k*W +: W] !== e_ar && bad == 0) begin
                what = $sformatf("rev A tap%0d", k); act = rev_taps_a[k*W +: W]; exp = e_ar;
            end
            if (rev_taps_a[k*W +: W] !== e_ar) bad++;
            if (fwd_taps_b[k*W +: W] !== e_bf && bad == 0) begin
                what = $sformatf("fwd B tap%0d", k); act = fwd_taps_b[k*W +: W]; exp = e_bf;
            end
            if (fwd_taps_b[k*W +: W] !== e_bf) bad++;
            if (rev_taps_b[k*W +: W] !== e_br && bad == 0) begin
                what = $sformatf("rev B tap%0d", k); act = rev_taps_b[k*W +: W]; exp = e_br;
            end
            if (rev_taps_b[k*W +: W] !== e_br) bad++;
        end
        // R9: tails mirror tap 3
        if (fwd_tail_a !== fwd_taps_a[3*W +: W] && bad == 0) begin
            what = "tail A (R9)"; act = fwd_tail_a; exp = fwd_taps_a[3*W +: W];
        end
        if (fwd_tail_a !== fwd_taps_a[3*W +: W]) bad++;
        if (fwd_tail_b !== fwd_taps_b[3*W +: W] && bad == 0) begin
            what = "tail B (R9)"; act = fwd_tail_b; exp = fwd_taps_b[3*W +: W];
        end
        if (fwd_tail_b !== fwd_taps_b[3*W +: W]) bad++;
        ntests++;
        if (bad != 0) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h (%0d mismatches)", tag, what, act, exp, bad);
        end
    endtask

    task automatic do_reset(input logic [3:0] code);
        @(negedge clk);
        rst = 1'b1; dec_code = code;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        spacing = int'(code) + 1;
    endtask

    // One cycle: check the state left by the previous edge, then drive new inputs.
    task automatic run_cycles(input int n, input logic en, input string tag);
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            check_all(tag);
            ce = en;
            din_a = W'($urandom); din_b = W'($urandom);
            fb_a_in = W'($urandom); fb_b_in = W'($urandom);
        end
    endtask

    task automatic t_reset_state;
        dual_mode = 1'b1; b_src_sel = 1'b0;
        do_reset(4'd0);
        @(negedge clk);
        check_all("R7 reset state");
    endtask

    task automatic t_unit_spacing;
        dual_mode = 1'b1; b_src_sel = 1'b0;
        do_reset(4'b0000);
        run_cycles(40, 1'b1, "R1 R2 R3 R9 code 0000");
    endtask

    task automatic t_max_spacing_src_b;
        dual_mode = 1'b1; b_src_sel = 1'b1;
        do_reset(4'b1111);
        run_cycles(150, 1'b1, "R2 R5 code 1111 source B");
    endtask

    task automatic t_src_a;
        dual_mode = 1'b1; b_src_sel = 1'b0;
        do_reset(4'd5);
        run_cycles(60, 1'b1, "R5 source A, din_b ignored");
    endtask

    task automatic t_cascade;
        dual_mode = 1'b0; b_src_sel = 1'b1;
        do_reset(4'd2);
        run_cycles(70, 1'b1, "R4 cascade, din_b fb_b ignored");
    endtask

    task automatic t_hold;
        dual_mode = 1'b1; b_src_sel = 1'b0;
        do_reset(4'd3);
        run_cycles(30, 1'b1, "R8 fill");
        run_cycles(12, 1'b0, "R8 ce low hold");
        run_cycles(20, 1'b1, "R8 resume");
    endtask

    task automatic t_code_change;
        dual_mode = 1'b1; b_src_sel = 1'b1;
        do_reset(4'd2);
        run_cycles(20, 1'b1, "R6 before change");
        @(negedge clk);
        dec_code = 4'd9;
        run_cycles(50, 1'b1, "R6 code ignored outside reset");
    endtask

    task automatic t_reset_midrun;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check_all("R7 mid-run reset clears");
        rst = 1'b0;
        spacing = int'(dec_code) + 1;
        run_cycles(40, 1'b1, "R6 new code after reset");
    endtask

    initial begin
        #(TCLK * 200000);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", ntests, nfail);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_unit_spacing();
        t_max_spacing_src_b();
        t_src_a();
        t_cascade();
        t_hold();
        t_code_change();
        t_reset_midrun();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end

endmodule